// File: doc/BRIEF.md
# Calendar Port Scheduler

This block picks the port that a transmit path serves next. It walks a programmable calendar table one slot at a time. Each slot holds a port number. For the port in the current slot, the block looks at two things: the flow-control state reported by the far end and whether local data is waiting. If that port may be served, the block raises a one-cycle grant that carries the port number. It then holds on that slot until the data mover answers with a done pulse. If the port may not be served, the block emits a one-cycle idle marker and moves on to the next slot in the following cycle.

Two calendar tables are kept, a main one and a shadow one. While one table drives service, software can rewrite the other one. A configuration write then selects the new table. The number of slots in use also comes from configuration. A new selection or a new length is only adopted when the slot index wraps back to zero, so a pass through the calendar is never cut short. A length outside the legal window is refused and raises an error flag.

Every event (grant or idle) also reports the slot index and the table it was read from. Downstream logic and the checks can therefore follow the calendar order directly.

Top module: `cal_poll_sched`

## Requirements
- R1: After reset: grant_o and idle_o are low and cfg_err_o is low. Entry i of both tables holds port i mod NUM_PORTS, the length in use is NUM_PORTS, and table 0 (main) is active.
- R2: A write with cfg_ent_we_i high stores cfg_ent_port_i at index cfg_ent_addr_i of table cfg_ent_bank_i (0 = main, 1 = shadow). Later events for that slot report that port.
- R3: Slots are visited in the order 0, 1, ..., length-1, 0, and each visit produces exactly one event. An event is grant_o or idle_o high for one cycle, never both. Each event reports the slot on slot_o, the table on bank_o and the slot's port on port_o.
- R4: When the slot's port has data_avail_i low, an idle event is produced and the next slot is evaluated in the following cycle.
- R5: A port whose 2-bit far-end status (fe_status_i[2p+1:2p]) is 0 (starving) or 1 (hungry) and whose data_avail_i bit is high receives a grant. The grant lasts exactly one cycle.
- R6: A port whose far-end status is 2 (satisfied) or 3 (reserved, handled as satisfied) produces an idle event, whatever its data_avail_i bit.
- R7: A length write with a value below NUM_PORTS or above MAX_CAL_LEN is refused: cfg_err_o goes high and the pending length is kept. A length write inside that window becomes the pending length and clears cfg_err_o.
- R8: A pending length and a pending table select are adopted only when the slot index advances from the last slot back to slot 0.
- R9: After a grant, no further event is produced until done_i is sampled high. A done_i pulse while no grant is outstanding has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_ent_we_i | input | 1 | Calendar entry write strobe |
| cfg_ent_bank_i | input | 1 | Table written (0 main, 1 shadow) |
| cfg_ent_addr_i | input | IDX_W (10) | Entry index written |
| cfg_ent_port_i | input | PORT_W (3) | Port number stored |
| cfg_len_we_i | input | 1 | Length write strobe |
| cfg_len_i | input | LEN_W (11) | Requested number of slots in use |
| cfg_bank_we_i | input | 1 | Table select write strobe |
| cfg_bank_i | input | 1 | Requested active table |
| fe_status_i | input | 2*NUM_PORTS (16) | Far-end status, 2 bits per port |
| data_avail_i | input | NUM_PORTS (8) | Local data waiting, 1 bit per port |
| done_i | input | 1 | Data mover finished the granted slot |
| grant_o | output | 1 | One-cycle grant for port_o |
| idle_o | output | 1 | One-cycle idle for the current slot |
| port_o | output | PORT_W (3) | Port of the reported slot |
| slot_o | output | IDX_W (10) | Index of the reported slot |
| bank_o | output | 1 | Table of the reported slot |
| cfg_err_o | output | 1 | Last length write was refused |

## Verification
The bench keeps the configuration changes away from the cycle in which a slot is evaluated. It rewrites lengths and table selects while a grant is outstanding, so each one has to wait for the next wrap. A design that applied them at once would report a slot index or a table that breaks the expected order right away. Lengths at both legal edges, one below the window and one above it are all written. A design with an off-by-one window check would flip the error flag wrongly, and one that kept a refused value would wrap at the wrong slot. Port status is re-randomised across all four codes, so any confusion between hungry, satisfied and the reserved code shows up as a grant in place of an idle or the reverse. Done pulses are also driven during idle streams, and the bench checks that no event appears while a grant is still waiting for done.

// File: rtl/cal_poll_pkg.sv
package cal_poll_pkg;

   // far-end flow-control state for one port
   typedef enum logic [1:0] {
      FE_STARVING  = 2'd0,
      FE_HUNGRY    = 2'd1,
      FE_SATISFIED = 2'd2,
      FE_RESERVED  = 2'd3
   } fe_status_e;

   typedef enum logic {
      SEQ_EVAL = 1'b0,
      SEQ_WAIT = 1'b1
   } seq_state_e;

   // a port may only receive data while the far end asks for it
   function automatic logic fe_may_serve(input logic [1:0] st);
      return (st == FE_STARVING) || (st == FE_HUNGRY);
   endfunction

endpackage

// File: rtl/cal_poll_table.sv
module cal_poll_table #(
   parameter int NUM_PORTS = 8,
   parameter int CAL_DEPTH = 1024,
   parameter int PORT_W    = 3,
   parameter int IDX_W     = 10
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              we_i,
   input  logic              wbank_i,
   input  logic [IDX_W-1:0]  waddr_i,
   input  logic [PORT_W-1:0] wport_i,
   input  logic              rbank_i,
   input  logic [IDX_W-1:0]  raddr_i,
   output logic [PORT_W-1:0] rport_o
);

   localparam int NUM_BANKS = 2;

   logic [PORT_W-1:0] rd_bank [NUM_BANKS];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [PORT_W-1:0] mem [CAL_DEPTH];
      logic              hit;

      assign hit = we_i && (wbank_i == b[0]);

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            for (int i = 0; i < CAL_DEPTH; i++)
               mem[i] <= PORT_W'(i % NUM_PORTS);
         end else if (hit) begin
            mem[waddr_i] <= wport_i;
         end
      end

      assign rd_bank[b] = mem[raddr_i];
   end

   assign rport_o = rbank_i ? rd_bank[1] : rd_bank[0];

endmodule

// File: rtl/cal_poll_cfg.sv
module cal_poll_cfg #(
   parameter int NUM_PORTS   = 8,
   parameter int MAX_CAL_LEN = 1024,
   parameter int LEN_W       = 11
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             len_we_i,
   input  logic [LEN_W-1:0] len_i,
   input  logic             bank_we_i,
   input  logic             bank_i,
   input  logic             wrap_i,
   output logic [LEN_W-1:0] len_act_o,
   output logic             bank_act_o,
   output logic             cfg_err_o
);

   localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(NUM_PORTS);
   localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_CAL_LEN);

   logic [LEN_W-1:0] len_pend_q, len_act_q;
   logic             bank_pend_q, bank_act_q, err_q;
   logic             len_ok;

   assign len_ok = (len_i >= LEN_MIN) && (len_i <= LEN_MAX);

   // pending copies take software writes at any time
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         len_pend_q  <= LEN_MIN;
         bank_pend_q <= 1'b0;
         err_q       <= 1'b0;
      end else begin
         if (len_we_i) begin
            err_q <= !len_ok;
            if (len_ok) len_pend_q <= len_i;
         end
         if (bank_we_i) bank_pend_q <= bank_i;
      end
   end

   // live copies move only at the calendar wrap
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         len_act_q  <= LEN_MIN;
         bank_act_q <= 1'b0;
      end else if (wrap_i) begin
         len_act_q  <= len_pend_q;
         bank_act_q <= bank_pend_q;
      end
   end

   assign len_act_o  = len_act_q;
   assign bank_act_o = bank_act_q;
   assign cfg_err_o  = err_q;

endmodule

// File: rtl/cal_poll_seq.sv
module cal_poll_seq
   import cal_poll_pkg::*;
#(
   parameter int NUM_PORTS = 8,
   parameter int PORT_W    = 3,
   parameter int IDX_W     = 10,
   parameter int LEN_W     = 11
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic [2*NUM_PORTS-1:0] fe_status_i,
   input  logic [NUM_PORTS-1:0]   data_avail_i,
   input  logic                   done_i,
   input  logic [PORT_W-1:0]      ent_port_i,
   input  logic [LEN_W-1:0]       len_act_i,
   input  logic                   bank_act_i,
   output logic [IDX_W-1:0]       slot_o,
   output logic                   wrap_o,
   output logic                   busy_o,
   output logic                   grant_o,
   output logic                   idle_o,
   output logic [PORT_W-1:0]      port_o,
   output logic [IDX_W-1:0]       ev_slot_o,
   output logic                   ev_bank_o
);

   localparam int PORT_SPAN = 1 << PORT_W;

   seq_state_e           state_q;
   logic [IDX_W-1:0]     slot_q, slot_nxt, ev_slot_q;
   logic [PORT_W-1:0]    port_q;
   logic                 grant_q, idle_q, ev_bank_q;
   logic [PORT_SPAN-1:0] elig;
   logic                 cur_ok, advance, last_slot;

   // per-port eligibility; codes beyond NUM_PORTS are never eligible
   for (genvar p = 0; p < PORT_SPAN; p++) begin : g_elig
      if (p < NUM_PORTS) begin : g_real
         assign elig[p] = fe_may_serve(fe_status_i[2*p +: 2]) && data_avail_i[p];
      end else begin : g_pad
         assign elig[p] = 1'b0;
      end
   end

   assign cur_ok    = elig[ent_port_i];
   assign advance   = ((state_q == SEQ_EVAL) && !cur_ok) ||
                      ((state_q == SEQ_WAIT) && done_i);
   assign last_slot = ({1'b0, slot_q} == (len_act_i - LEN_W'(1)));
   assign slot_nxt  = last_slot ? '0 : slot_q + IDX_W'(1);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q   <= SEQ_EVAL;
         slot_q    <= '0;
         grant_q   <= 1'b0;
         idle_q    <= 1'b0;
         port_q    <= '0;
         ev_slot_q <= '0;
         ev_bank_q <= 1'b0;
      end else begin
         grant_q <= 1'b0;
         idle_q  <= 1'b0;
         if (state_q == SEQ_EVAL) begin
            port_q    <= ent_port_i;
            ev_slot_q <= slot_q;
            ev_bank_q <= bank_act_i;
            if (cur_ok) begin
               grant_q <= 1'b1;
               state_q <= SEQ_WAIT;
            end else begin
               idle_q  <= 1'b1;
            end
         end else if (done_i) begin
            state_q <= SEQ_EVAL;
         end
         if (advance) slot_q <= slot_nxt;
      end
   end

   assign slot_o    = slot_q;
   assign wrap_o    = advance && last_slot;
   assign busy_o    = (state_q == SEQ_WAIT);
   assign grant_o   = grant_q;
   assign idle_o    = idle_q;
   assign port_o    = port_q;
   assign ev_slot_o = ev_slot_q;
   assign ev_bank_o = ev_bank_q;

endmodule

// File: rtl/cal_poll_sched.sv
module cal_poll_sched #(
   parameter int NUM_PORTS   = 8,
   parameter int CAL_DEPTH   = 1024,
   parameter int MAX_CAL_LEN = 1024,
   parameter int PORT_W      = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
   parameter int IDX_W       = $clog2(CAL_DEPTH),
   parameter int LEN_W       = IDX_W + 1
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   cfg_ent_we_i,
   input  logic                   cfg_ent_bank_i,
   input  logic [IDX_W-1:0]       cfg_ent_addr_i,
   input  logic [PORT_W-1:0]      cfg_ent_port_i,
   input  logic                   cfg_len_we_i,
   input  logic [LEN_W-1:0]       cfg_len_i,
   input  logic                   cfg_bank_we_i,
   input  logic                   cfg_bank_i,
   input  logic [2*NUM_PORTS-1:0] fe_status_i,
   input  logic [NUM_PORTS-1:0]   data_avail_i,
   input  logic                   done_i,
   output logic                   grant_o,
   output logic                   idle_o,
   output logic [PORT_W-1:0]      port_o,
   output logic [IDX_W-1:0]       slot_o,
   output logic                   bank_o,
   output logic                   cfg_err_o
);

   // elaboration-time parameter checks
   if (NUM_PORTS < 1) begin : g_chk_ports
      $error("cal_poll_sched: NUM_PORTS must be at least 1");
   end
   if ((1 << IDX_W) != CAL_DEPTH) begin : g_chk_depth
      $error("cal_poll_sched: CAL_DEPTH must be a power of two");
   end
   if ((MAX_CAL_LEN > CAL_DEPTH) || (MAX_CAL_LEN < NUM_PORTS)) begin : g_chk_max
      $error("cal_poll_sched: MAX_CAL_LEN must lie in [NUM_PORTS, CAL_DEPTH]");
   end
   if (LEN_W <= IDX_W) begin : g_chk_lenw
      $error("cal_poll_sched: LEN_W must exceed IDX_W");
   end

   logic [IDX_W-1:0]  cur_slot;
   logic [PORT_W-1:0] ent_port;
   logic [LEN_W-1:0]  len_act;
   logic              bank_act, wrap, busy;

   cal_poll_table #(
      .NUM_PORTS (NUM_PORTS),
      .CAL_DEPTH (CAL_DEPTH),
      .PORT_W    (PORT_W),
      .IDX_W     (IDX_W)
   ) u_table (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (cfg_ent_we_i),
      .wbank_i (cfg_ent_bank_i),
      .waddr_i (cfg_ent_addr_i),
      .wport_i (cfg_ent_port_i),
      .rbank_i (bank_act),
      .raddr_i (cur_slot),
      .rport_o (ent_port)
   );

   cal_poll_cfg #(
      .NUM_PORTS   (NUM_PORTS),
      .MAX_CAL_LEN (MAX_CAL_LEN),
      .LEN_W       (LEN_W)
   ) u_cfg (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .len_we_i   (cfg_len_we_i),
      .len_i      (cfg_len_i),
      .bank_we_i  (cfg_bank_we_i),
      .bank_i     (cfg_bank_i),
      .wrap_i     (wrap),
      .len_act_o  (len_act),
      .bank_act_o (bank_act),
      .cfg_err_o  (cfg_err_o)
   );

   cal_poll_seq #(
      .NUM_PORTS (NUM_PORTS),
      .PORT_W    (PORT_W),
      .IDX_W     (IDX_W),
      .LEN_W     (LEN_W)
   ) u_seq (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .fe_status_i  (fe_status_i),
      .data_avail_i (data_avail_i),
      .done_i       (done_i),
      .ent_port_i   (ent_port),
      .len_act_i    (len_act),
      .bank_act_i   (bank_act),
      .slot_o       (cur_slot),
      .wrap_o       (wrap),
      .busy_o       (busy),
      .grant_o      (grant_o),
      .idle_o       (idle_o),
      .port_o       (port_o),
      .ev_slot_o    (slot_o),
      .ev_bank_o    (bank_o)
   );

endmodule

// File: rtl/cal_poll_sva.sv
module cal_poll_sva
   import cal_poll_pkg::*;
#(
   parameter int NUM_PORTS   = 8,
   parameter int MAX_CAL_LEN = 1024,
   parameter int PORT_W      = 3,
   parameter int IDX_W       = 10,
   parameter int LEN_W       = 11
) (
   input logic                   clk_i,
   input logic                   rst_ni,
   input logic                   cfg_len_we_i,
   input logic [LEN_W-1:0]       cfg_len_i,
   input logic [2*NUM_PORTS-1:0] fe_status_i,
   input logic [NUM_PORTS-1:0]   data_avail_i,
   input logic                   done_i,
   input logic                   grant_o,
   input logic                   idle_o,
   input logic [PORT_W-1:0]      port_o,
   input logic [IDX_W-1:0]       slot_o,
   input logic                   bank_o,
   input logic                   cfg_err_o,
   input logic                   busy,
   input logic [LEN_W-1:0]       len_act
);

   localparam int PORT_SPAN = 1 << PORT_W;

   logic [2*PORT_SPAN-1:0] st_q;
   logic [PORT_SPAN-1:0]   av_q;
   logic                   last_bank_q;
   logic                   ev, len_bad, st_ok;

   assign ev      = grant_o || idle_o;
   assign len_bad = (cfg_len_i < LEN_W'(NUM_PORTS)) || (cfg_len_i > LEN_W'(MAX_CAL_LEN));
   assign st_ok   = fe_may_serve(st_q[{port_o, 1'b0} +: 2]) && av_q[port_o];

   // inputs as seen by the slot decision one cycle earlier
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q        <= '0;
         av_q        <= '0;
         last_bank_q <= 1'b0;
      end else begin
         st_q <= (2*PORT_SPAN)'(fe_status_i);
         av_q <= PORT_SPAN'(data_avail_i);
         if (ev) last_bank_q <= bank_o;
      end
   end

   assert_one_event_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(grant_o && idle_o));

   assert_slot_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev |-> ({1'b0, slot_o} < $past(len_act)));

   assert_grant_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant_o |=> !grant_o);

   assert_grant_eligible_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant_o |-> st_ok);

   assert_idle_ineligible_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      idle_o |-> !st_ok);

   assert_len_reject_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_len_we_i && len_bad) |=> cfg_err_o);

   assert_len_accept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_len_we_i && !len_bad) |=> !cfg_err_o);

   assert_bank_at_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev && (bank_o != last_bank_q)) |-> (slot_o == '0));

   assert_hold_for_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy && !done_i) |=> !ev);

endmodule

bind cal_poll_sched cal_poll_sva #(
   .NUM_PORTS   (NUM_PORTS),
   .MAX_CAL_LEN (MAX_CAL_LEN),
   .PORT_W      (PORT_W),
   .IDX_W       (IDX_W),
   .LEN_W       (LEN_W)
) u_sva (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .cfg_len_we_i (cfg_len_we_i),
   .cfg_len_i    (cfg_len_i),
   .fe_status_i  (fe_status_i),
   .data_avail_i (data_avail_i),
   .done_i       (done_i),
   .grant_o      (grant_o),
   .idle_o       (idle_o),
   .port_o       (port_o),
   .slot_o       (slot_o),
   .bank_o       (bank_o),
   .cfg_err_o    (cfg_err_o),
   .busy         (busy),
   .len_act      (len_act)
);

// File: tb/cal_poll_sched_tb_top.sv
module cal_poll_sched_tb_top;

   localparam int NP     = 8;
   localparam int DEPTH  = 1024;
   localparam int MAXL   = 1024;
   localparam int PW     = 3;
   localparam int IW     = 10;
   localparam int LW     = 11;
   localparam int GRANTS = 2500;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ent_we = 1'b0, ent_bank = 1'b0;
   logic [IW-1:0] ent_addr = '0;
   logic [PW-1:0] ent_port = '0;
   logic          len_we = 1'b0;
   logic [LW-1:0] len_val = '0;
   logic          bank_we = 1'b0, bank_val = 1'b0;
   logic [2*NP-1:0] fe_st = '0;
   logic [NP-1:0] avail = '1;
   logic          done = 1'b0;
   logic          grant, idle, cfg_err, bank;
   logic [PW-1:0] port;
   logic [IW-1:0] slot;

   int errors = 0;
   int checks = 0;

   // bench model of the calendar
   int cal_m [2][DEPTH];
   int len_a, len_p, bank_a, bank_p, slot_m;

   always #5 clk = ~clk;

   cal_poll_sched #(
      .NUM_PORTS (NP), .CAL_DEPTH (DEPTH), .MAX_CAL_LEN (MAXL)
   ) dut_i (
      .clk_i (clk), .rst_ni (rst_n),
      .cfg_ent_we_i (ent_we), .cfg_ent_bank_i (ent_bank),
      .cfg_ent_addr_i (ent_addr), .cfg_ent_port_i (ent_port),
      .cfg_len_we_i (len_we), .cfg_len_i (len_val),
      .cfg_bank_we_i (bank_we), .cfg_bank_i (bank_val),
      .fe_status_i (fe_st), .data_avail_i (avail), .done_i (done),
      .grant_o (grant), .idle_o (idle), .port_o (port),
      .slot_o (slot), .bank_o (bank), .cfg_err_o (cfg_err)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic bit port_elig(input int p);
      return (fe_st[2*p +: 2] < 2'd2) && avail[p];
   endfunction

   function automatic bit port_sat(input int p);
      return fe_st[2*p +: 2] >= 2'd2;
   endfunction

   function automatic void model_advance();
      if (slot_m == len_a - 1) begin
         slot_m = 0;
         len_a  = len_p;   // R8: adopted only at the wrap
         bank_a = bank_p;
      end else begin
         slot_m++;
      end
   endfunction

   // waits for the next event, checks it; returns 1 for a grant
   task automatic next_event(output bit was_grant);
      int  ep;
      bit  el;
      int  guard;
      guard = 0;
      do begin
         @(negedge clk);
         done = 1'b0;
         guard++;
      end while (!(grant || idle) && guard < 20);
      chk(grant || idle, "R3", "event missing", 0, 1);
      ep = cal_m[bank_a][slot_m];
      el = port_elig(ep);
      chk(slot == IW'(slot_m), "R3", "slot order", int'(slot), slot_m);
      chk(bank == bank_a[0], "R8", "table in use", int'(bank), bank_a);
      chk(port == PW'(ep), "R2", "slot port", int'(port), ep);
      chk(!(grant && idle), "R3", "grant with idle", 1, 0);
      if (el) chk(grant, "R5", "grant for eligible port", int'(grant), 1);
      else if (port_sat(ep)) chk(idle, "R6", "idle for satisfied port", int'(idle), 1);
      else chk(idle, "R4", "idle for empty port", int'(idle), 1);
      was_grant = grant;
      if (!grant) begin
         model_advance();
         // R9: stray done while evaluating
         if (($urandom % 8) == 0) done = 1'b1;
      end
   endtask

   task automatic quiet_cycle();
      @(negedge clk);
      chk(!grant && !idle, "R9", "event while waiting for done",
          int'(grant) + int'(idle), 0);
   endtask

   task automatic write_len(input int v);
      bit ok;
      ok      = (v >= NP) && (v <= MAXL);
      len_we  = 1'b1;
      len_val = LW'(v);
      quiet_cycle();
      len_we  = 1'b0;
      chk(cfg_err == !ok, "R7", "length error flag", int'(cfg_err), int'(!ok));
      if (ok) len_p = v;
   endtask

   task automatic write_bank(input int b);
      bank_we  = 1'b1;
      bank_val = b[0];
      quiet_cycle();
      bank_we  = 1'b0;
      bank_p   = b;
   endtask

   task automatic write_entry(input int b, input int a, input int p);
      ent_we   = 1'b1;
      ent_bank = b[0];
      ent_addr = IW'(a);
      ent_port = PW'(p);
      quiet_cycle();
      ent_we   = 1'b0;
      cal_m[b][a] = p;
   endtask

   task automatic rand_status();
      for (int p = 0; p < NP; p++) begin
         fe_st[2*p +: 2] = 2'($urandom % 4);
         avail[p]        = ($urandom % 3) != 0;
      end
      // port 0 stays eligible; slot 0 of both tables always holds it
      fe_st[1:0] = 2'($urandom % 2);
      avail[0]   = 1'b1;
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      bit g;
      void'($urandom(32'd4242));
      for (int b = 0; b < 2; b++)
         for (int i = 0; i < DEPTH; i++) cal_m[b][i] = i % NP;
      len_a = NP; len_p = NP; bank_a = 0; bank_p = 0; slot_m = 0;

      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!grant && !idle, "R1", "no event in reset", int'(grant) + int'(idle), 0);
      chk(!cfg_err, "R1", "error flag in reset", int'(cfg_err), 0);
      rst_n = 1'b1;

      for (int n = 0; n < GRANTS; n++) begin
         do next_event(g); while (!g);
         // grant outstanding: configuration and status changes happen here
         quiet_cycle();
         case (n)
            4:  begin write_len(NP - 1); write_len(MAXL + 1); end
            6:  write_len(12);
            8:  begin write_len(0); write_len(MAXL); write_len(NP); end
            10: begin
                   for (int a = 1; a < 12; a++) write_entry(1, a, $urandom % NP);
                   write_bank(1);
                end
            default: begin
               if (($urandom % 4) == 0) rand_status();
               if (($urandom % 4) == 0)
                  write_entry($urandom % 2, 1 + ($urandom % 39), $urandom % NP);
               if (($urandom % 12) == 0) write_len($urandom % 50);
               if (($urandom % 12) == 0) write_bank($urandom % 2);
            end
         endcase
         repeat ($urandom % 3) quiet_cycle();
         done = 1'b1;
         model_advance();
         @(negedge clk);
         done = 1'b0;
         chk(!grant && !idle, "R9", "event before re-evaluation",
             int'(grant) + int'(idle), 0);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule